// File: doc/BRIEF.md
# Shared Work-RAM Host Window with Mailbox Snooping

This block is a slave on a simple synchronous host bus. It gives a host processor access to a 16-bit work RAM that a coprocessor also uses through a second port. The host can reach the RAM in three ways. A linear window allows byte and word reads and writes. Two read-only "cell arrange" windows permute the word-address bits, so data stored in tile order can be read back in a different layout. Writes into either permuting window finish on the bus and leave the RAM untouched.

The block also watches host word writes to two mailbox words in the lower half of the linear window. A non-zero write to a mailbox word releases the matching coprocessor wait flag. The coprocessor raises each flag through its own set input. The RAM is an internal array of `2**RAM_AW` words, and every window maps into it modulo that depth. Covering the full linear window takes `RAM_AW = 16`. Bus arbitration is left to the surrounding system.

Top module: `shram_host_window`

## Requirements
- R1: A host word write (`host_be` = 2'b11) to an address in 0x300000–0x31FFFF stores `host_wdata` at word index `(addr >> 1) mod 2**RAM_AW`. A later host read of that address returns the word on `host_rdata` one clock after the cycle in which `host_rd` is high.
- R2: In a linear-window write, `host_be[1]` writes bits 15:8 (the byte at the even address) and `host_be[0]` writes bits 7:0. A lane whose enable is low keeps its old value. Address bit 0 is ignored.
- R3: A host read in 0x390000–0x39FFFF, with w = addr >> 1, returns the RAM word at index `{w[14:12], w[5:1], w[11:6], w[0]}` taken modulo the RAM depth.
- R4: A host read in 0x3A0000–0x3AFFFF, with w = addr >> 1, returns the RAM word at index `{w[14:11], w[4:1], w[10:5], w[0]}` taken modulo the RAM depth.
- R5: Host writes to either permuting window leave every RAM word unchanged.
- R6: A host word write of a non-zero value to 0x30FE06 clears `wait_a`, and one to 0x30FE08 clears `wait_b`. The flag goes low on the clock edge that takes the write. The other flag is unaffected.
- R7: A host word write of zero to a mailbox address stores the zero and leaves both flags unchanged.
- R8: Only word writes in the lower half (0x300000–0x30FFFF) are snooped. A byte write to a mailbox address, or a word write to 0x31FE06/0x31FE08, leaves the flags unchanged.
- R9: `cop_set_a`/`cop_set_b` high in a cycle makes the matching flag 1 after that clock edge. This also holds when a snooped clear of the same flag falls in the same cycle.
- R10: While `host_rd` is low, `host_rdata` holds its value. A read of any address outside the three windows returns 0.
- R11: A `cop_we` write stores `cop_wdata` at `cop_addr`. `cop_rdata` shows, one clock later, the word that was at `cop_addr` before that edge. If both ports write the same word in one cycle, the host's enabled lanes win.
- R12: After reset, `host_rdata`, `cop_rdata`, `wait_a` and `wait_b` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 24 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_be | input | 2 | Byte enables: [1] bits 15:8, [0] bits 7:0 |
| host_rdata | output | 16 | Registered host read data |
| cop_addr | input | RAM_AW | Coprocessor word index |
| cop_we | input | 1 | Coprocessor write enable |
| cop_wdata | input | 16 | Coprocessor write data |
| cop_rdata | output | 16 | Registered coprocessor read data |
| cop_set_a | input | 1 | Raise wait flag A |
| cop_set_b | input | 1 | Raise wait flag B |
| wait_a | output | 1 | Wait flag A |
| wait_b | output | 1 | Wait flag B |

## Verification
Two events can land on the same flag in the same cycle: a coprocessor set and a snooped non-zero mailbox write. Directed cycles drive both together for each flag. Random cycles also let them collide, because mailbox addresses are chosen often and the set inputs toggle at random. A bench model checks after every edge that a set always beats a clear. It also checks that host and coprocessor writes to the same word in one cycle resolve lane by lane in favour of the host.

// File: rtl/shram_pkg.sv
package shram_pkg;
    localparam int HOST_AW = 24;
    localparam int DW      = 16;

    localparam logic [6:0]  LIN_PAGE  = 7'h18;   // addr[23:17] for 0x300000-0x31FFFF
    localparam logic [7:0]  CELL1_PAGE = 8'h39;  // addr[23:16]
    localparam logic [7:0]  CELL2_PAGE = 8'h3A;
    localparam logic [14:0] MBOX_A_W  = 15'h7F03; // byte offset 0xFE06 >> 1
    localparam logic [14:0] MBOX_B_W  = 15'h7F04; // byte offset 0xFE08 >> 1

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_LINEAR,
        WIN_CELL1,
        WIN_CELL2
    } win_e;

    typedef struct packed {
        logic wait_a;
        logic wait_b;
    } flag_s;

    typedef struct packed {
        logic [DW-1:0] host;
        logic [DW-1:0] cop;
    } rd_s;

    function automatic logic [15:0] cell1_index(input logic [15:0] w);
        return {1'b0, w[14:12], w[5:1], w[11:6], w[0]};
    endfunction

    function automatic logic [15:0] cell2_index(input logic [15:0] w);
        return {1'b0, w[14:11], w[4:1], w[10:5], w[0]};
    endfunction
endpackage

// File: rtl/shram_addr_decode.sv
module shram_addr_decode
    import shram_pkg::*;
#(
    parameter int RAM_AW = 11
) (
    input  logic [HOST_AW-1:0] addr,
    output win_e               win,
    output logic [RAM_AW-1:0]  idx,
    output logic               mbox_a,
    output logic               mbox_b
);
    logic [15:0] w;
    logic [15:0] full_idx;
    logic        lower_half;
    logic        unused_bit0;

    assign w           = addr[16:1];
    assign unused_bit0 = addr[0];

    always_comb begin
        win      = WIN_NONE;
        full_idx = w;
        if (addr[23:17] == LIN_PAGE) begin
            win      = WIN_LINEAR;
            full_idx = w;
        end else if (addr[23:16] == CELL1_PAGE) begin
            win      = WIN_CELL1;
            full_idx = cell1_index(w);
        end else if (addr[23:16] == CELL2_PAGE) begin
            win      = WIN_CELL2;
            full_idx = cell2_index(w);
        end
    end

    assign idx        = full_idx[RAM_AW-1:0];
    assign lower_half = (win == WIN_LINEAR) && !addr[16];
    assign mbox_a     = lower_half && (addr[15:1] == MBOX_A_W);
    assign mbox_b     = lower_half && (addr[15:1] == MBOX_B_W);
endmodule

// File: rtl/shram_mailbox_snoop.sv
module shram_mailbox_snoop
    import shram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic snoop_en,
    input  logic wdata_nz,
    input  logic hit_a,
    input  logic hit_b,
    input  logic set_a,
    input  logic set_b,
    output logic wait_a,
    output logic wait_b
);
    flag_s flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (snoop_en && wdata_nz && hit_a) flag_d.wait_a = 1'b0;
        if (snoop_en && wdata_nz && hit_b) flag_d.wait_b = 1'b0;
        if (set_a) flag_d.wait_a = 1'b1;
        if (set_b) flag_d.wait_b = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign wait_a = flag_q.wait_a;
    assign wait_b = flag_q.wait_b;
endmodule

// File: rtl/shram_store.sv
module shram_store
    import shram_pkg::*;
#(
    parameter int RAM_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAM_AW-1:0] h_idx,
    input  logic [1:0]        h_lanes,
    input  logic [DW-1:0]     h_wdata,
    input  logic              h_re,
    input  logic              h_in_win,
    output logic [DW-1:0]     h_rdata,
    input  logic [RAM_AW-1:0] c_idx,
    input  logic              c_we,
    input  logic [DW-1:0]     c_wdata,
    output logic [DW-1:0]     c_rdata
);
    localparam int DEPTH = 1 << RAM_AW;
    localparam int BW    = DW / 2;

    logic [DW-1:0] mem [DEPTH];
    rd_s rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (h_re) rd_d.host = h_in_win ? mem[h_idx] : '0;
        rd_d.cop = mem[c_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    // Host lanes are applied after the coprocessor word, so they win a tie.
    always_ff @(posedge clk) begin
        if (c_we) mem[c_idx] <= c_wdata;
        if (h_lanes[1]) mem[h_idx][DW-1:BW] <= h_wdata[DW-1:BW];
        if (h_lanes[0]) mem[h_idx][BW-1:0]  <= h_wdata[BW-1:0];
    end

    assign h_rdata = rd_q.host;
    assign c_rdata = rd_q.cop;
endmodule

// File: rtl/shram_host_window.sv
module shram_host_window
    import shram_pkg::*;
#(
    parameter int RAM_AW = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [1:0]         host_be,
    output logic [DW-1:0]      host_rdata,
    input  logic [RAM_AW-1:0]  cop_addr,
    input  logic               cop_we,
    input  logic [DW-1:0]      cop_wdata,
    output logic [DW-1:0]      cop_rdata,
    input  logic               cop_set_a,
    input  logic               cop_set_b,
    output logic               wait_a,
    output logic               wait_b
);
    win_e              win;
    logic [RAM_AW-1:0] idx;
    logic              mbox_a, mbox_b;
    logic [1:0]        lanes;
    logic              snoop_en;

    shram_addr_decode #(.RAM_AW(RAM_AW)) dec_i (
        .addr   (host_addr),
        .win    (win),
        .idx    (idx),
        .mbox_a (mbox_a),
        .mbox_b (mbox_b)
    );

    assign lanes    = (host_wr && win == WIN_LINEAR) ? host_be : 2'b00;
    assign snoop_en = host_wr && (host_be == 2'b11);

    shram_store #(.RAM_AW(RAM_AW)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_idx    (idx),
        .h_lanes  (lanes),
        .h_wdata  (host_wdata),
        .h_re     (host_rd),
        .h_in_win (win != WIN_NONE),
        .h_rdata  (host_rdata),
        .c_idx    (cop_addr),
        .c_we     (cop_we),
        .c_wdata  (cop_wdata),
        .c_rdata  (cop_rdata)
    );

    shram_mailbox_snoop snoop_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .snoop_en (snoop_en),
        .wdata_nz (host_wdata != '0),
        .hit_a    (mbox_a),
        .hit_b    (mbox_b),
        .set_a    (cop_set_a),
        .set_b    (cop_set_b),
        .wait_a   (wait_a),
        .wait_b   (wait_b)
    );
endmodule

// File: rtl/shram_host_window_chk.sv
module shram_host_window_chk
    import shram_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [HOST_AW-1:0] host_addr,
    input logic [DW-1:0]      host_wdata,
    input logic               host_rd,
    input logic               host_wr,
    input logic [1:0]         host_be,
    input logic [DW-1:0]      host_rdata,
    input logic               cop_set_a,
    input logic               cop_set_b,
    input logic               wait_a,
    input logic               wait_b
);
    logic lo_page, in_any;
    assign lo_page = host_addr[23:16] == 8'h30;
    assign in_any  = (host_addr[23:17] == LIN_PAGE) || (host_addr[23:16] == CELL1_PAGE)
                  || (host_addr[23:16] == CELL2_PAGE);

    p_clear_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_be == 2'b11 && lo_page && host_addr[15:1] == MBOX_A_W
         && host_wdata != '0 && !cop_set_a) |=> !wait_a);

    p_clear_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_be == 2'b11 && lo_page && host_addr[15:1] == MBOX_B_W
         && host_wdata != '0 && !cop_set_b) |=> !wait_b);

    p_zero_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata == '0 && !cop_set_a && !cop_set_b)
        |=> ($stable(wait_a) && $stable(wait_b)));

    p_byte_no_snoop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_be != 2'b11 && !cop_set_a && !cop_set_b)
        |=> ($stable(wait_a) && $stable(wait_b)));

    p_set_a_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cop_set_a |=> wait_a);

    p_set_b_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cop_set_b |=> wait_b);

    p_rise_needs_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_a) |-> $past(cop_set_a));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

    p_outside_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !in_any) |=> host_rdata == '0);
endmodule

bind shram_host_window shram_host_window_chk chk_i (.*);

// File: tb/shram_host_window_tb_top.sv
module shram_host_window_tb_top;
    localparam int RAM_AW = 11;
    localparam int DEPTH  = 1 << RAM_AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [23:0]       host_addr = '0;
    logic [15:0]       host_wdata = '0;
    logic              host_rd = 1'b0, host_wr = 1'b0;
    logic [1:0]        host_be = '0;
    logic [15:0]       host_rdata, cop_rdata;
    logic [RAM_AW-1:0] cop_addr = '0;
    logic              cop_we = 1'b0;
    logic [15:0]       cop_wdata = '0;
    logic              cop_set_a = 1'b0, cop_set_b = 1'b0;
    logic              wait_a, wait_b;

    shram_host_window #(.RAM_AW(RAM_AW)) dut_i (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [15:0] mem_m [DEPTH];
    logic [15:0] rd_m = '0;
    logic wa_m = 1'b0, wb_m = 1'b0;

    function automatic int win_of(input logic [23:0] a);
        if (a[23:17] == 7'h18) return 1;
        if (a[23:16] == 8'h39) return 2;
        if (a[23:16] == 8'h3A) return 3;
        return 0;
    endfunction

    function automatic int unsigned ram_idx(input logic [23:0] a);
        int unsigned w, r;
        w = 32'(a) >> 1;
        case (win_of(a))
            1: r = w & 32'hFFFF;
            2: r = (w & 32'h7001) | ((w & 32'h3E) << 6) | ((w & 32'hFC0) >> 5);
            3: r = (w & 32'h7801) | ((w & 32'h1E) << 6) | ((w & 32'h7E0) >> 4);
            default: r = 0;
        endcase
        return r & (DEPTH - 1);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic hrd, input logic hwr, input logic [23:0] a,
                        input logic [15:0] wd, input logic [1:0] be,
                        input logic cwe, input logic [RAM_AW-1:0] cidx,
                        input logic [15:0] cwd, input logic sa, input logic sb,
                        input string tag);
        logic [15:0] exp_crd;
        int wn;
        int unsigned ix;
        logic hit_ok;
        host_rd = hrd; host_wr = hwr; host_addr = a; host_wdata = wd; host_be = be;
        cop_we = cwe; cop_addr = cidx; cop_wdata = cwd; cop_set_a = sa; cop_set_b = sb;
        wn = win_of(a);
        ix = ram_idx(a);
        if (hrd) rd_m = (wn != 0) ? mem_m[ix] : 16'h0000;
        exp_crd = mem_m[cidx];
        if (cwe) mem_m[cidx] = cwd;
        if (hwr && wn == 1) begin
            if (be[1]) mem_m[ix][15:8] = wd[15:8];
            if (be[0]) mem_m[ix][7:0]  = wd[7:0];
        end
        hit_ok = hwr && be == 2'b11 && wn == 1 && !a[16] && wd != 16'h0000;
        if (hit_ok && a[15:1] == 15'h7F03) wa_m = 1'b0;
        if (hit_ok && a[15:1] == 15'h7F04) wb_m = 1'b0;
        if (sa) wa_m = 1'b1;
        if (sb) wb_m = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " host_rdata"}, host_rdata, rd_m);
        chk("R11 cop_rdata", cop_rdata, exp_crd);
        chk({tag, " wait_a"}, {15'd0, wait_a}, {15'd0, wa_m});
        chk({tag, " wait_b"}, {15'd0, wait_b}, {15'd0, wb_m});
    endtask

    task automatic hw(input logic [23:0] a, input logic [15:0] d, input logic [1:0] be, input string tag);
        step(1'b0, 1'b1, a, d, be, 1'b0, '0, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic hr(input logic [23:0] a, input string tag);
        step(1'b1, 1'b0, a, '0, 2'b11, 1'b0, '0, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic sets(input logic sa, input logic sb);
        step(1'b0, 1'b0, 24'h0, '0, 2'b00, 1'b0, '0, '0, sa, sb, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk("R12 host_rdata", host_rdata, 16'h0);
        chk("R12 cop_rdata", cop_rdata, 16'h0);
        chk("R12 wait_a", {15'd0, wait_a}, 16'h0);
        chk("R12 wait_b", {15'd0, wait_b}, 16'h0);

        // R11: fill RAM from coprocessor port
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, 1'b0, 24'h0, '0, 2'b00, 1'b1, RAM_AW'(i), 16'($urandom), 1'b0, 1'b0, "R11");
        for (int i = 0; i < 8; i++)
            step(1'b0, 1'b0, 24'h0, '0, 2'b00, 1'b0, RAM_AW'(i * 37), '0, 1'b0, 1'b0, "R11");

        // R9: set flags
        sets(1'b1, 1'b1);
        // R7: zero writes to both mailboxes keep flags, data stored
        hw(24'h30FE06, 16'h0000, 2'b11, "R7");
        hw(24'h30FE08, 16'h0000, 2'b11, "R7");
        hr(24'h30FE06, "R7");
        // R6: non-zero clears only matching flag
        hw(24'h30FE06, 16'h0042, 2'b11, "R6");
        hr(24'h30FE06, "R1");
        sets(1'b1, 1'b0);
        hw(24'h30FE08, 16'h8000, 2'b11, "R6");
        sets(1'b0, 1'b1);
        // R8: byte writes and upper-half writes not snooped
        hw(24'h30FE06, 16'hFFFF, 2'b10, "R8");
        hw(24'h30FE08, 16'hFFFF, 2'b01, "R8");
        hw(24'h31FE06, 16'h1111, 2'b11, "R8");
        hw(24'h31FE08, 16'h2222, 2'b11, "R8");
        // R9: set and clear collide
        step(1'b0, 1'b1, 24'h30FE06, 16'h0001, 2'b11, 1'b0, '0, '0, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b1, 24'h30FE08, 16'h0001, 2'b11, 1'b0, '0, '0, 1'b0, 1'b1, "R9");
        // R2: byte lanes
        hw(24'h300100, 16'h1234, 2'b11, "R2");
        hw(24'h300101, 16'hAB00, 2'b10, "R2");
        hr(24'h300100, "R2");
        hw(24'h300100, 16'h00CD, 2'b01, "R2");
        hr(24'h300100, "R2");
        // R3 / R4 directed
        hr(24'h390002, "R3");
        hr(24'h39ABCE, "R3");
        hr(24'h3A0040, "R4");
        hr(24'h3A5A5A, "R4");
        // R5: writes to permuting windows ignored
        hw(24'h390100, 16'hDEAD, 2'b11, "R5");
        hr(24'h390100, "R5");
        hw(24'h3A0100, 16'hBEEF, 2'b11, "R5");
        hr(24'h3A0100, "R5");
        // R10: outside windows and hold
        hr(24'hA15000, "R10");
        hr(24'h300100, "R10");
        step(1'b0, 1'b0, 24'h0, '0, 2'b00, 1'b0, '0, '0, 1'b0, 1'b0, "R10");
        // R11: same-cycle host and cop write to one word, host lanes win
        step(1'b0, 1'b1, 24'h300010, 16'h5500, 2'b10, 1'b1, RAM_AW'(8), 16'h00AA, 1'b0, 1'b0, "R11");
        hr(24'h300010, "R11");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int unsigned r, k;
            logic [23:0] a;
            logic [1:0] be;
            string tag;
            r = $urandom;
            k = r % 8;
            be = 2'($urandom);
            a = 24'h0;
            case (k)
                0, 1, 2, 3, 4: begin
                    a = {7'h18, 17'($urandom)};
                    if ($urandom % 5 == 0) a = ($urandom % 2 != 0) ? 24'h30FE06 : 24'h30FE08;
                    if ($urandom % 8 == 0) a[16] = 1'b1;
                end
                5: a = {8'h39, 16'($urandom)};
                6: a = {8'h3A, 16'($urandom)};
                default: a = {8'hA1, 16'($urandom)};
            endcase
            a[0] = 1'b0;
            if (k <= 2) tag = (be == 2'b11) ? "R6" : "R2";
            else if (k <= 4) tag = "R1";
            else if (k == 5) tag = "R3";
            else if (k == 6) tag = "R4";
            else tag = "R10";
            if (k <= 2 || (k >= 5 && ($urandom % 3 == 0))) begin
                if (k >= 5) tag = "R5";
                step(1'b0, 1'b1, a, ($urandom % 4 == 0) ? 16'h0 : 16'($urandom), be,
                     ($urandom % 4 == 0), RAM_AW'($urandom), 16'($urandom),
                     ($urandom % 10 == 0), ($urandom % 10 == 0), tag);
            end else begin
                step(1'b1, 1'b0, a, '0, 2'b11,
                     ($urandom % 4 == 0), RAM_AW'($urandom), 16'($urandom),
                     ($urandom % 10 == 0), ($urandom % 10 == 0), tag);
            end
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule